// File: doc/BRIEF.md
# Four-Channel DS1 Byte-Multiplexed Serial Transmitter

This block builds one 16.384 Mbit/s serial transmit stream that carries four 1.544 Mbit/s DS1 channels. It runs on a single 16.384 MHz bit clock. A frame sync input aligns it. Each frame lasts 2048 bit periods. Every source bit goes out on two consecutive bit periods. The frame opens with one octet that holds the four channels' framing bits. A gap of seven zero octets follows it. Then comes the payload, interleaved by channel inside each timeslot. The frame closes with zero octets.

The block fetches its data through a per-channel read port. It drives a channel index and a timeslot index on that port. The port must return the addressed payload octet and the addressed channel's framing bit one clock later, so a registered memory or register file can sit behind it directly. Without further syncs the block keeps running at 2048 bits per frame. A sync that arrives anywhere else in the frame restarts the frame at once.

Top module: `ds1x4_byte_mux`

## Requirements
- R1: With no sync, the frame repeats every 2048 clock cycles. The bit pattern of one frame follows the previous frame without a gap.
- R2: After reset, ser_o stays 0 until the first sync has been sampled.
- R3: Frame position 0 appears on ser_o after the second rising edge that follows the edge sampling sync_i high. Position p follows p cycles later.
- R4: Positions 0 to 7 carry the framing bits. Positions 2c and 2c+1 both carry the framing bit of channel c, for c = 0 to 3.
- R5: Positions 8 to 63 are driven as 0.
- R6: Positions 64 to 1599 carry the payload, with timeslot as the outer order and channel as the inner order. Each channel-timeslot octet fills 16 positions starting at 64 + 64*ts + 16*ch. Its bits go out from rd_data_i[7] down to rd_data_i[0], and each bit is sent twice.
- R7: Positions 1600 to 2047 are driven as 0.
- R8: A sync sampled at any position other than the expected wrap restarts the frame at position 0. A sync that coincides with the expected wrap leaves the stream unchanged.
- R9: The read address (rd_ch_o, rd_ts_o) is driven one clock before its data is used, and it always stays within 0..3 and 0..23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16.384 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame sync; high for one cycle at frame start |
| rd_ch_o | output | 2 | Channel index of the read request |
| rd_ts_o | output | 5 | Timeslot index of the read request |
| rd_data_i | input | 8 | Payload octet for the previous cycle's address |
| rd_fbit_i | input | 1 | Framing bit of the previous cycle's channel |
| ser_o | output | 1 | Serial transmit data, changes on the rising edge |

## Verification
The bench checks every bit position of whole frames against a memory model whose contents change from frame to frame.

- **Free-running frames.** A design with the wrong frame length, or one that only runs while sync keeps arriving, breaks the second frame.
- **Sync at the wrap.** A sync placed exactly on the wrap boundary catches a design that glitches or drops a bit on a redundant sync.
- **Mid-frame resyncs.** Resyncs are placed inside the payload, inside the zero gap and inside the framing octet. They catch a restart that lands off by a cycle, or old pipeline bits that are lost or corrupted.
- **Payload interleave.** Wrong interleave order, a single rather than doubled bit, LSB-first order, or a missed registered-read delay each show up as wrong payload bits.

// File: rtl/ds1x4_mux_pkg.sv
package ds1x4_mux_pkg;

    typedef enum logic [1:0] {
        SLOT_FILL = 2'd0,
        SLOT_FBIT = 2'd1,
        SLOT_PAY  = 2'd2
    } slot_kind_e;

endpackage

// File: rtl/ds1x4_frame_counter.sv
module ds1x4_frame_counter #(
    parameter int FRAME_BITS = 2048,
    parameter int POS_W      = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    output logic [POS_W-1:0] pos_o,
    output logic             live_o
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             live;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_i) begin
            st_d.pos  = '0;
            st_d.live = 1'b1;
        end else if (st_q.pos == LAST_POS) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o  = st_q.pos;
    assign live_o = st_q.live;

endmodule

// File: rtl/ds1x4_slot_mapper.sv
module ds1x4_slot_mapper
    import ds1x4_mux_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int NUM_TS     = 24,
    parameter int REP        = 2,
    parameter int GAP_OCTETS = 7,
    parameter int POS_W      = 11,
    parameter int CH_W       = 2,
    parameter int TS_W       = 5
) (
    input  logic [POS_W-1:0] pos_i,
    output slot_kind_e       kind_o,
    output logic [CH_W-1:0]  ch_o,
    output logic [TS_W-1:0]  ts_o,
    output logic [2:0]       sbit_o
);

    localparam int FBIT_END   = NUM_CH * REP;
    localparam int PAY_START  = 8 * (1 + GAP_OCTETS);
    localparam int BITS_CH_TS = 8 * REP;
    localparam int BITS_TS    = BITS_CH_TS * NUM_CH;
    localparam int PAY_END    = PAY_START + NUM_TS * BITS_TS;

    always_comb begin
        int p;
        int q;
        int r;
        p      = int'(pos_i);
        q      = 0;
        r      = 0;
        kind_o = SLOT_FILL;
        ch_o   = '0;
        ts_o   = '0;
        sbit_o = '0;
        if (p < FBIT_END) begin
            kind_o = SLOT_FBIT;
            ch_o   = CH_W'(p / REP);
        end else if (p >= PAY_START && p < PAY_END) begin
            q      = p - PAY_START;
            r      = q % BITS_TS;
            kind_o = SLOT_PAY;
            ts_o   = TS_W'(q / BITS_TS);
            ch_o   = CH_W'(r / BITS_CH_TS);
            sbit_o = 3'((r % BITS_CH_TS) / REP);
        end
    end

endmodule

// File: rtl/ds1x4_serial_stage.sv
module ds1x4_serial_stage
    import ds1x4_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  slot_kind_e kind_i,
    input  logic [2:0] sbit_i,
    input  logic       live_i,
    input  logic [7:0] rd_data_i,
    input  logic       rd_fbit_i,
    output logic       ser_o
);

    typedef struct packed {
        slot_kind_e kind1;
        logic [2:0] sbit1;
        logic       live1;
        logic       ser;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.kind1 = kind_i;
        st_d.sbit1 = sbit_i;
        st_d.live1 = live_i;
        st_d.ser   = 1'b0;
        if (st_q.live1) begin
            unique case (st_q.kind1)
                SLOT_FBIT: st_d.ser = rd_fbit_i;
                SLOT_PAY:  st_d.ser = rd_data_i[3'd7 - st_q.sbit1];
                default:   st_d.ser = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{kind1: SLOT_FILL, sbit1: 3'd0, live1: 1'b0, ser: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_o = st_q.ser;

endmodule

// File: rtl/ds1x4_byte_mux.sv
module ds1x4_byte_mux
    import ds1x4_mux_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int NUM_TS     = 24,
    parameter int REP        = 2,
    parameter int GAP_OCTETS = 7,
    parameter int FRAME_BITS = 2048,
    parameter int CH_W       = $clog2(NUM_CH),
    parameter int TS_W       = $clog2(NUM_TS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_i,
    output logic [CH_W-1:0] rd_ch_o,
    output logic [TS_W-1:0] rd_ts_o,
    input  logic [7:0]      rd_data_i,
    input  logic            rd_fbit_i,
    output logic            ser_o
);

    localparam int POS_W = $clog2(FRAME_BITS);

    logic [POS_W-1:0] frame_pos;
    logic             frame_live;
    slot_kind_e       slot_kind;
    logic [2:0]       slot_sbit;

    ds1x4_frame_counter #(
        .FRAME_BITS (FRAME_BITS),
        .POS_W      (POS_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .pos_o  (frame_pos),
        .live_o (frame_live)
    );

    ds1x4_slot_mapper #(
        .NUM_CH     (NUM_CH),
        .NUM_TS     (NUM_TS),
        .REP        (REP),
        .GAP_OCTETS (GAP_OCTETS),
        .POS_W      (POS_W),
        .CH_W       (CH_W),
        .TS_W       (TS_W)
    ) u_map (
        .pos_i  (frame_pos),
        .kind_o (slot_kind),
        .ch_o   (rd_ch_o),
        .ts_o   (rd_ts_o),
        .sbit_o (slot_sbit)
    );

    ds1x4_serial_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind_i    (slot_kind),
        .sbit_i    (slot_sbit),
        .live_i    (frame_live),
        .rd_data_i (rd_data_i),
        .rd_fbit_i (rd_fbit_i),
        .ser_o     (ser_o)
    );

endmodule

// File: rtl/ds1x4_mux_chk.sv
module ds1x4_mux_chk #(
    parameter int NUM_CH     = 4,
    parameter int NUM_TS     = 24,
    parameter int REP        = 2,
    parameter int GAP_OCTETS = 7,
    parameter int FRAME_BITS = 2048,
    parameter int POS_W      = 11,
    parameter int CH_W       = 2,
    parameter int TS_W       = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sync_i,
    input logic [POS_W-1:0] pos,
    input logic            live,
    input logic [CH_W-1:0] rd_ch,
    input logic [TS_W-1:0] rd_ts,
    input logic            rd_fbit,
    input logic            ser
);

    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] FBIT_END  = POS_W'(NUM_CH * REP);
    localparam logic [POS_W-1:0] PAY_START = POS_W'(8 * (1 + GAP_OCTETS));
    localparam logic [POS_W-1:0] PAY_END   = POS_W'(8 * (1 + GAP_OCTETS) + NUM_TS * NUM_CH * 8 * REP);

    // R8
    sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (pos == '0));

    // R1
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && pos == LAST_POS) |=> (pos == '0));

    // R1
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && pos != LAST_POS) |=> (pos == $past(pos) + 1'b1));

    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> ##2 !ser);

    // R4
    fbit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && pos < FBIT_END) |-> ##2 (ser == $past(rd_fbit)));

    // R5
    gap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= FBIT_END && pos < PAY_START) |-> ##2 !ser);

    // R7
    tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= PAY_END) |-> ##2 !ser);

    // R9
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_ch) < NUM_CH) && (int'(rd_ts) < NUM_TS));

endmodule

bind ds1x4_byte_mux ds1x4_mux_chk #(
    .NUM_CH     (NUM_CH),
    .NUM_TS     (NUM_TS),
    .REP        (REP),
    .GAP_OCTETS (GAP_OCTETS),
    .FRAME_BITS (FRAME_BITS),
    .POS_W      (POS_W),
    .CH_W       (CH_W),
    .TS_W       (TS_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (sync_i),
    .pos     (frame_pos),
    .live    (frame_live),
    .rd_ch   (rd_ch_o),
    .rd_ts   (rd_ts_o),
    .rd_fbit (rd_fbit_i),
    .ser     (ser_o)
);

// File: tb/ds1x4_byte_mux_tb.sv
module ds1x4_byte_mux_tb_top;

    localparam int FRAME = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_i = 1'b0;
    logic [1:0] rd_ch;
    logic [4:0] rd_ts;
    logic [7:0] rd_data = 8'h00;
    logic       rd_fbit = 1'b0;
    logic       ser;
    int         seed = 1;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    ds1x4_byte_mux dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_i),
        .rd_ch_o   (rd_ch),
        .rd_ts_o   (rd_ts),
        .rd_data_i (rd_data),
        .rd_fbit_i (rd_fbit),
        .ser_o     (ser)
    );

    function automatic logic [7:0] pay_byte(int ch, int ts, int s);
        return 8'(((ch * 73 + ts * 29 + s * 151 + 13) ^ (ts << 3)) & 255);
    endfunction

    function automatic logic f_bit(int ch, int s);
        return 1'((s >> ch) & 1);
    endfunction

    // R9: registered read port, one clock of latency
    always @(posedge clk) begin
        rd_data <= pay_byte(int'(rd_ch), int'(rd_ts), seed);
        rd_fbit <= f_bit(int'(rd_ch), seed);
    end

    function automatic logic exp_bit(int p, int s);
        int q;
        int r;
        logic [7:0] b;
        if (p < 8) return f_bit(p / 2, s);
        if (p < 64) return 1'b0;
        if (p >= 1600) return 1'b0;
        q = p - 64;
        r = q % 64;
        b = pay_byte(r / 16, q / 64, s);
        return b[7 - ((r % 16) / 2)];
    endfunction

    function automatic string req_of(int p);
        if (p < 8) return "R4";
        if (p < 64) return "R5";
        if (p < 1600) return "R6";
        return "R7";
    endfunction

    task automatic check(string req, int p, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pos %0d: got %0b expected %0b", req, p, act, exp);
        end
    endtask

    // Checks one frame bit by bit; optional resync at resync_at (R8, R3)
    task automatic check_frame(int s, int resync_at, int next_seed);
        for (int p = 0; p < FRAME; p++) begin
            if (resync_at >= 0 && p == resync_at + 3) return;
            @(negedge clk);
            check(req_of(p), p, ser, exp_bit(p, s));
            checks++;
            if (int'(rd_ch) >= 4 || int'(rd_ts) >= 24) begin
                errors++;
                $display("FAIL R9 pos %0d: address ch %0d ts %0d expected ch<4 ts<24",
                         p, rd_ch, rd_ts);
            end
            if (resync_at >= 0 && p == resync_at) sync_i = 1'b1;
            if (resync_at >= 0 && p == resync_at + 1) begin
                sync_i = 1'b0;
                seed   = next_seed;
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        seed = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: output held low before any sync
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check("R2", i, ser, 1'b0);
        end
        // R3: sync sampled at edge E, position 0 shown after E+2
        sync_i = 1'b1;
        @(negedge clk);
        sync_i = 1'b0;
        @(negedge clk);
        // R8: sync exactly at the expected wrap must not disturb
        check_frame(1, 2045, 2);
        // R1: free-running frame without sync
        check_frame(2, -1, 2);
        // R8: resync inside payload
        check_frame(2, 700, 3);
        // R8: resync inside the zero gap
        check_frame(3, 40, 4);
        // R8: resync inside the framing octet
        check_frame(4, 5, 5);
        // R1, R6: full frame after restart
        check_frame(5, -1, 5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule